// File: doc/BRIEF.md
# Interrupt Register Bank Stack

This block keeps CPU contexts for an interrupt controller in hardware. When the CPU accepts an interrupt that is allowed to use banking, the block stores one full working-register context in one of fifteen bank slots. The stored context is nineteen 32-bit CPU registers plus the 32-bit vector table offset of that interrupt. A restore request later returns the most recent context that has not yet been restored.

The slot for the next save is given by a bank-number counter, which software can read. A save stores the context at the current count and then adds one. A restore first subtracts one and then returns the slot at the new count. Every operation takes a single clock cycle. A save attempted while all slots are in use sets a sticky overflow flag. A restore attempted while no slot holds data sets a sticky underflow flag. Only reset clears these two flags.

Top module: `irq_ctx_stack`

## Requirements
- R1: After reset, bank_num is 0, empty is 1, full is 0, and overflow, underflow and ctx_valid are all 0.
- R2: In a cycle where irq_accept and bank_allow are both 1 and bank_num is below 15, ctx_in is stored in the slot whose index equals bank_num, and bank_num increases by one on that edge.
- R3: An accepted interrupt with bank_allow at 0 does not save and leaves bank_num unchanged.
- R4: A restore_req with no save in the same cycle and bank_num above 0 lowers bank_num by one. From the same edge, ctx_out holds the slot at the new bank_num and ctx_valid is 1 for exactly one cycle.
- R5: Slots fill upward from slot 0. Restores return contexts in reverse order of saving, newest first, including after saves and restores are mixed.
- R6: full is 1 exactly when bank_num is 15. empty is 1 exactly when bank_num is 0.
- R7: A save attempted when bank_num is 15 stores nothing and leaves bank_num at 15. It sets overflow, and overflow stays at 1 until reset.
- R8: A restore attempted when bank_num is 0 produces no ctx_valid and leaves bank_num at 0. It sets underflow, and underflow stays at 1 until reset.
- R9: When a save and a restore_req happen in the same cycle, the save is performed and the restore is ignored. No ctx_valid is produced for it.
- R10: The context bus holds 32-bit word k in bits [32k+31:32k]. Words 0 to 14 are R0 to R14. Word 15 is the global base register, word 16 is the multiply-accumulate high half, word 17 is the multiply-accumulate low half, word 18 is the procedure register and word 19 is the vector table offset. A restore returns every word at the same position it was saved in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_accept | input | 1 | CPU accepts an interrupt this cycle |
| bank_allow | input | 1 | The accepted interrupt may use register banks |
| restore_req | input | 1 | Restore the newest saved context |
| ctx_in | input | 640 | Context to save, 20 words of 32 bits |
| ctx_out | output | 640 | Restored context, same word layout |
| ctx_valid | output | 1 | One-cycle pulse when ctx_out is freshly restored |
| bank_num | output | 4 | Current bank number (next slot to save into) |
| full | output | 1 | All fifteen slots hold contexts |
| empty | output | 1 | No slot holds a context |
| overflow | output | 1 | Sticky: a save was refused at full |
| underflow | output | 1 | Sticky: a restore was refused at empty |

## Verification
The bench fills all fifteen slots and then drains them. Every word of every restored context is compared with a value computed from the slot, the word index and a generation number. An off-by-one in the write or read address, or a swapped field, therefore shows up as a wrong word in some slot. The bench also tries a save at full, a restore at empty, a non-banked interrupt and a simultaneous save and restore. A design that wraps the counter, writes a slot it should not, emits a spurious valid pulse or lets restore win the tie would change bank_num or the returned data. Later interleaved pushes and pops check that the sticky flags stay set and that slots reused after a pop return only their newest contents.

// File: rtl/ctx_bank_pkg.sv
package ctx_bank_pkg;
  // word positions inside one saved context
  localparam int N_GPR    = 15;
  localparam int IDX_GBR  = N_GPR;
  localparam int IDX_MACH = N_GPR + 1;
  localparam int IDX_MACL = N_GPR + 2;
  localparam int IDX_PR   = N_GPR + 3;
  localparam int IDX_VTO  = N_GPR + 4;
  localparam int N_WORDS  = N_GPR + 5;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_OVF,
    OP_UNF
  } bank_op_e;
endpackage

// File: rtl/ctx_bank_ctrl.sv
module ctx_bank_ctrl
  import ctx_bank_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int BN_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_accept,
  input  logic            bank_allow,
  input  logic            restore_req,
  output logic            wr_en,
  output logic [BN_W-1:0] wr_addr,
  output logic            rd_en,
  output logic [BN_W-1:0] rd_addr,
  output logic [BN_W-1:0] bn,
  output logic            full,
  output logic            empty,
  output logic            ovf,
  output logic            unf
);
  localparam logic [BN_W-1:0] TOP = BN_W'(DEPTH);
  localparam logic [BN_W-1:0] ONE = BN_W'(1);

  bank_op_e op;
  logic     save_hit;
  logic     at_top;
  logic     at_bot;

  assign save_hit = irq_accept & bank_allow;
  assign at_top   = (bn == TOP);
  assign at_bot   = (bn == '0);

  // save wins over restore when both arrive together
  always_comb begin
    if (save_hit)         op = at_top ? OP_OVF : OP_PUSH;
    else if (restore_req) op = at_bot ? OP_UNF : OP_POP;
    else                  op = OP_IDLE;
  end

  assign wr_en   = (op == OP_PUSH);
  assign rd_en   = (op == OP_POP);
  assign wr_addr = bn;
  assign rd_addr = bn - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      bn    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      case (op)
        OP_PUSH: begin
          bn    <= bn + ONE;
          full  <= (bn == TOP - ONE);
          empty <= 1'b0;
        end
        OP_POP: begin
          bn    <= bn - ONE;
          empty <= (bn == ONE);
          full  <= 1'b0;
        end
        OP_OVF:  ovf <= 1'b1;
        OP_UNF:  unf <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
    (save_hit && !full) |=> (bn == $past(bn) + ONE));
  assert_unbanked_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_accept && !bank_allow && !restore_req) |=> $stable(bn));
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_hit && !empty) |=> (bn == $past(bn) - ONE));
  assert_full_flag_R6: assert property (@(posedge clk) disable iff (rst)
    full == (bn == TOP));
  assert_empty_flag_R6: assert property (@(posedge clk) disable iff (rst)
    empty == (bn == '0));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (save_hit && full) |=> (ovf && bn == TOP));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_hit && empty) |=> (unf && bn == '0));
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);
  assert_bn_range_R6: assert property (@(posedge clk) disable iff (rst)
    bn <= TOP);
endmodule

// File: rtl/ctx_bank_ram.sv
module ctx_bank_ram #(
  parameter int DEPTH = 15,
  parameter int AW    = 4,
  parameter int W     = 640
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rvalid
);
  // plain array with synchronous read so block RAM can be inferred
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  always_comb begin
    if (!rst) begin
      assert_no_rw_clash_R9: assert (!(we && re));
    end
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import ctx_bank_pkg::*;
#(
  parameter int DEPTH  = 15,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          irq_accept,
  input  logic                          bank_allow,
  input  logic                          restore_req,
  input  logic [N_WORDS*DATA_W-1:0]     ctx_in,
  output logic [N_WORDS*DATA_W-1:0]     ctx_out,
  output logic                          ctx_valid,
  output logic [$clog2(DEPTH+1)-1:0]    bank_num,
  output logic                          full,
  output logic                          empty,
  output logic                          overflow,
  output logic                          underflow
);
  localparam int BN_W  = $clog2(DEPTH + 1);
  localparam int CTX_W = N_WORDS * DATA_W;

  logic            wr_en;
  logic            rd_en;
  logic [BN_W-1:0] wr_addr;
  logic [BN_W-1:0] rd_addr;

  ctx_bank_ctrl #(
    .DEPTH (DEPTH),
    .BN_W  (BN_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .irq_accept  (irq_accept),
    .bank_allow  (bank_allow),
    .restore_req (restore_req),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .bn          (bank_num),
    .full        (full),
    .empty       (empty),
    .ovf         (overflow),
    .unf         (underflow)
  );

  ctx_bank_ram #(
    .DEPTH (DEPTH),
    .AW    (BN_W),
    .W     (CTX_W)
  ) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .waddr  (wr_addr),
    .wdata  (ctx_in),
    .re     (rd_en),
    .raddr  (rd_addr),
    .rdata  (ctx_out),
    .rvalid (ctx_valid)
  );

  assert_restore_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !(irq_accept && bank_allow) && !empty)
      |=> (ctx_valid && bank_num == $past(bank_num) - BN_W'(1)));
  assert_save_blocks_restore_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_accept && bank_allow) |=> !ctx_valid);
  assert_refused_pop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !(irq_accept && bank_allow) && empty) |=> !ctx_valid);
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    (ctx_valid && !$past(rd_en)) |-> 1'b0);
endmodule

// File: tb/irq_ctx_stack_bench.sv
module irq_ctx_stack_bench;
  import ctx_bank_pkg::*;
  localparam int CLK_P = 10;
  localparam int DEPTH = 15;
  localparam int DW    = 32;
  localparam int CW    = N_WORDS * DW;

  logic          clk = 1'b0;
  logic          rst;
  logic          irq_accept, bank_allow, restore_req;
  logic [CW-1:0] ctx_in;
  logic [CW-1:0] ctx_out;
  logic          ctx_valid, full, empty, overflow, underflow;
  logic [3:0]    bank_num;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_ctx_stack u_irq_ctx_stack (
    .clk(clk), .rst(rst), .irq_accept(irq_accept), .bank_allow(bank_allow),
    .restore_req(restore_req), .ctx_in(ctx_in), .ctx_out(ctx_out),
    .ctx_valid(ctx_valid), .bank_num(bank_num), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [31:0] pat(int g, int s, int k);
    return {g[7:0], s[7:0], k[7:0], 8'h5A};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(int g, int s);
    for (int k = 0; k < N_WORDS; k++) ctx_in[k*DW +: DW] = pat(g, s, k);
  endtask

  // drive one cycle of stimulus, then sample at the following negedge
  task automatic cycle(bit acc, bit allow, bit rest, int g, int s);
    @(negedge clk);
    irq_accept = acc; bank_allow = allow; restore_req = rest;
    load(g, s);
    @(negedge clk);
    irq_accept = 0; bank_allow = 0; restore_req = 0;
  endtask

  task automatic check_ctx(string req, int g, int s);
    int bad = -1;
    for (int k = N_WORDS - 1; k >= 0; k--)
      if (ctx_out[k*DW +: DW] !== pat(g, s, k)) bad = k;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, ctx_out[bad*DW +: DW], pat(g, s, bad));
  endtask

  task automatic pop_check(string req, int g, int s);
    cycle(0, 0, 1, 0, 0);
    chk(ctx_valid === 1'b1, {req, " valid"}, 32'(ctx_valid), 1);
    chk(bank_num === 4'(s), {req, " bn"}, 32'(bank_num), 32'(s));
    check_ctx(req, g, s);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1; irq_accept = 0; bank_allow = 0; restore_req = 0; ctx_in = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(bank_num === 4'd0, "R1 bn", 32'(bank_num), 0);
    chk(empty === 1'b1 && full === 1'b0, "R1 flags", {30'd0, empty, full}, 2);
    chk(!overflow && !underflow && !ctx_valid, "R1 sticky/valid",
        {29'd0, overflow, underflow, ctx_valid}, 0);

    // R2 / R5 fill slots 0..14 upward; slot 7 written with restore also asserted (R9)
    for (int s = 0; s < DEPTH; s++) begin
      if (s == 5) begin
        cycle(1, 0, 0, 9, 5);   // R3 non-banked interrupt
        chk(bank_num === 4'd5, "R3 bn unchanged", 32'(bank_num), 5);
      end
      if (s == 7) begin
        cycle(1, 1, 1, 1, 7);
        chk(ctx_valid === 1'b0, "R9 no valid", 32'(ctx_valid), 0);
        chk(bank_num === 4'd8, "R9 save won", 32'(bank_num), 8);
      end else begin
        cycle(1, 1, 0, 1, s);
        chk(bank_num === 4'(s + 1), "R2 bn step", 32'(bank_num), 32'(s + 1));
      end
      chk(empty === 1'b0, "R6 not empty", 32'(empty), 0);
      chk(full === (s == DEPTH - 1), "R6 full", 32'(full), 32'(s == DEPTH - 1));
    end

    // R7 save at full
    cycle(1, 1, 0, 3, 14);
    chk(bank_num === 4'd15, "R7 bn held", 32'(bank_num), 15);
    chk(overflow === 1'b1, "R7 overflow", 32'(overflow), 1);

    // R4 / R5 / R10 drain newest first
    for (int s = DEPTH - 1; s >= 0; s--) begin
      pop_check("R5 drain", 1, s);
      if (s == DEPTH - 1) begin
        chk(ctx_out[IDX_VTO*DW +: DW] === pat(1, 14, 19), "R10 vector offset word",
            ctx_out[IDX_VTO*DW +: DW], pat(1, 14, 19));
        chk(ctx_out[IDX_GBR*DW +: DW] === pat(1, 14, 15), "R10 gbr word",
            ctx_out[IDX_GBR*DW +: DW], pat(1, 14, 15));
        @(negedge clk);
        chk(ctx_valid === 1'b0, "R4 single pulse", 32'(ctx_valid), 0);
      end
      chk(full === 1'b0, "R6 full clear", 32'(full), 0);
    end
    chk(empty === 1'b1, "R6 empty", 32'(empty), 1);

    // R8 restore at empty
    cycle(0, 0, 1, 0, 0);
    chk(ctx_valid === 1'b0, "R8 no valid", 32'(ctx_valid), 0);
    chk(bank_num === 4'd0, "R8 bn held", 32'(bank_num), 0);
    chk(underflow === 1'b1, "R8 underflow", 32'(underflow), 1);
    chk(overflow === 1'b1, "R7 overflow sticky", 32'(overflow), 1);

    // R5 interleaved: push 0..2, pop 2, push new 2 and 3, drain
    for (int s = 0; s < 3; s++) cycle(1, 1, 0, 2, s);
    pop_check("R5 mixed", 2, 2);
    cycle(1, 1, 0, 4, 2);
    cycle(1, 1, 0, 4, 3);
    pop_check("R5 mixed", 4, 3);
    pop_check("R5 reused slot", 4, 2);
    pop_check("R5 mixed", 2, 1);
    pop_check("R5 mixed", 2, 0);
    chk(underflow === 1'b1, "R8 underflow sticky", 32'(underflow), 1);
    summary();
  end
endmodule